// File: doc/BRIEF.md
# Black-Level Clamp Feedback Controller

This block is the digital half of an optical-black clamp loop in a video front end. Each video line carries a short optical-black pulse. After the active edge of that pulse the block collects a fixed run of ADC codes, averages them, and compares the average with a programmed black target. The difference becomes a signed correction that is added to a current-DAC code register. An external integrator and DAC, outside this block, turn that code back into an offset at the amplifier input.

The target comes from a 5-bit clamp setting. The measurement can cover a single line or be pooled over four lines. When the amplifier gain changes, the upstream logic pulses a strobe. The loop then moves into a fast lead-in mode that multiplies the correction by a selectable factor. The loop returns to its normal small step only after the error has stayed within a threshold for a programmable number of measurements. The code register saturates at both ends of its range and never wraps.

Top module: `blc_loop`

## Requirements
- R1: While rst_ni is low, dac_o is mid-scale (512 for a 10-bit code) and fast_o is 0. Reset also discards any partial window or partial 4-line sum.
- R2: The active OB level is ob_i XOR ob_inv_i. A clock edge that samples the active level after an inactive one is edge 0. The ADC codes sampled at edges 5 through 12 after it (eight codes) form the window. The window value is their sum shifted right by 3. Codes outside those edges have no effect.
- R3: The black target is clamp_sel_i × 2 + 14, which spans 14 to 76.
- R4: The error is target minus average, in signed 11-bit form. In normal mode the step is the error arithmetically shifted right by 3, which rounds toward minus infinity. dac_o takes dac_o + step at the clock edge after the last window sample, and changes at no other time.
- R5: If dac_o + step is below 0, dac_o becomes 0. If it is above 1023, dac_o becomes 1023.
- R6: With avg4_i = 1, a measurement is made only on every fourth completed window. Its average is the sum of all 32 codes shifted right by 5. The first three windows leave dac_o unchanged.
- R7: A gain_chg_i pulse sets fast_o at the next edge. While fast_o is 1, the step is the error times N, where mult_sel_i 00/01/10/11 selects N = 4/8/16/32.
- R8: While fast, a measurement whose error magnitude exceeds 32 keeps fast_o at 1 and restarts the hold count.
- R9: While fast, consecutive measurements with error magnitude of 32 or less are counted. When the count reaches 1/2/4/8 (hold_sel_i 00/01/10/11), fast_o clears. The measurement that completes the count still uses the fast step.
- R10: An active OB edge that arrives before a window has completed discards the partial sum and starts a new window from edge 0.
- R11: With ob_inv_i = 1 the OB pulse is active low, with identical window timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | ADC conversion clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_i | input | 10 | ADC output code |
| ob_i | input | 1 | Optical-black pulse, at least 2 clocks wide |
| ob_inv_i | input | 1 | 1 makes the OB pulse active low |
| clamp_sel_i | input | 5 | Black target setting |
| avg4_i | input | 1 | 1 pools the measurement over four lines |
| gain_chg_i | input | 1 | One-clock strobe on a gain change |
| mult_sel_i | input | 2 | Fast lead-in multiplier select |
| hold_sel_i | input | 2 | Fast lead-in exit hold count select |
| dac_o | output | 10 | Current-DAC correction code |
| fast_o | output | 1 | Fast lead-in mode active |

## Verification
The window is driven with codes that ramp with the clock index, and every code outside the window is held at full scale. This makes a window shifted by one clock change the average. Averages that give negative errors not divisible by eight separate floor rounding from truncation. Targets at both ends of the clamp range confirm the target formula. Four unequal lines in pooled mode separate a true 32-code average from a last-line result. In fast mode, an error of exactly 32, an error of -33 that interrupts the hold count, and each hold and multiplier setting pin down the exit rule. Large errors at the highest multiplier drive the code into both rails. An interrupted window filled with full-scale codes exposes any partial sum that survives a retrigger.

// File: rtl/blc_pkg.sv
package blc_pkg;

  typedef enum logic {
    LOOP_NORMAL = 1'b0,
    LOOP_FAST   = 1'b1
  } loop_mode_e;

  // black target = setting * 2 + 14
  function automatic logic [6:0] target_code(input logic [4:0] sel);
    return {1'b0, sel, 1'b0} + 7'd14;
  endfunction

  // fast multiplier as a left shift: 4, 8, 16, 32
  function automatic logic [2:0] mult_shift(input logic [1:0] sel);
    return {1'b0, sel} + 3'd2;
  endfunction

  // exit hold count: 1, 2, 4, 8 measurements
  function automatic logic [3:0] hold_count(input logic [1:0] sel);
    return 4'd1 << sel;
  endfunction

endpackage

// File: rtl/blc_obwin.sv
module blc_obwin #(
  parameter int CODE_W    = 10,
  parameter int WIN_FIRST = 5,
  parameter int WIN_LEN   = 8,
  localparam int WIN_LAST = WIN_FIRST + WIN_LEN - 1,
  localparam int CNT_W    = $clog2(WIN_LAST + 1),
  localparam int SUM_W    = CODE_W + $clog2(WIN_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              ob_i,
  input  logic              ob_inv_i,
  output logic              win_done_o,
  output logic [SUM_W-1:0]  win_sum_o
);

  logic             act, act_q, edge_s, in_win;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] acc_q, acc_d, sum_q, sum_d;
  logic             done_q, done_d;

  assign act    = ob_i ^ ob_inv_i;
  assign edge_s = act & ~act_q;
  assign in_win = (cnt_q >= CNT_W'(WIN_FIRST)) && (cnt_q <= CNT_W'(WIN_LAST));

  always_comb begin
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    sum_d  = sum_q;
    done_d = 1'b0;
    if (edge_s) begin
      // new pulse always restarts, partial sum is dropped
      cnt_d = CNT_W'(1);
      acc_d = '0;
    end else if (cnt_q != '0) begin
      if (cnt_q == CNT_W'(WIN_LAST)) begin
        cnt_d  = '0;
        acc_d  = '0;
        sum_d  = acc_q + SUM_W'(code_i);
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
        if (in_win) begin
          acc_d = acc_q + SUM_W'(code_i);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      sum_q  <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act;
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      sum_q  <= sum_d;
      done_q <= done_d;
    end
  end

  assign win_done_o = done_q;
  assign win_sum_o  = sum_q;

endmodule

// File: rtl/blc_avg.sv
module blc_avg #(
  parameter int CODE_W  = 10,
  parameter int WIN_LEN = 8,
  parameter int LINES   = 4,
  localparam int WIN_SH  = $clog2(WIN_LEN),
  localparam int LINE_SH = $clog2(LINES),
  localparam int SUM_W   = CODE_W + WIN_SH,
  localparam int TOT_W   = SUM_W + LINE_SH,
  localparam int LC_W    = (LINE_SH > 0) ? LINE_SH : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_done_i,
  input  logic [SUM_W-1:0]  win_sum_i,
  input  logic              avg4_i,
  output logic              meas_v_o,
  output logic [CODE_W-1:0] meas_code_o
);

  logic [LC_W-1:0]  line_q, line_d;
  logic [TOT_W-1:0] tot_q, tot_d, tot_now;
  logic             last_line;

  assign tot_now   = tot_q + TOT_W'(win_sum_i);
  assign last_line = !avg4_i || (line_q == LC_W'(LINES - 1));

  always_comb begin
    line_d = line_q;
    tot_d  = tot_q;
    if (win_done_i) begin
      if (last_line) begin
        line_d = '0;
        tot_d  = '0;
      end else begin
        line_d = line_q + LC_W'(1);
        tot_d  = tot_now;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      tot_q  <= '0;
    end else begin
      line_q <= line_d;
      tot_q  <= tot_d;
    end
  end

  assign meas_v_o    = win_done_i & last_line;
  // taking the top CODE_W bits divides by the sample count
  assign meas_code_o = avg4_i ? tot_now[TOT_W-1 -: CODE_W] : win_sum_i[SUM_W-1 -: CODE_W];

endmodule

// File: rtl/blc_lead.sv
module blc_lead
  import blc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       gain_chg_i,
  input  logic       meas_v_i,
  input  logic       err_big_i,
  input  logic [1:0] hold_sel_i,
  output logic       fast_o
);

  loop_mode_e mode_q, mode_d;
  logic [3:0] hold_q, hold_d, hold_inc;

  assign hold_inc = hold_q + 4'd1;

  always_comb begin
    mode_d = mode_q;
    hold_d = hold_q;
    if (gain_chg_i) begin
      mode_d = LOOP_FAST;
      hold_d = '0;
    end else if (meas_v_i && (mode_q == LOOP_FAST)) begin
      if (err_big_i) begin
        hold_d = '0;
      end else if (hold_inc >= hold_count(hold_sel_i)) begin
        mode_d = LOOP_NORMAL;
        hold_d = '0;
      end else begin
        hold_d = hold_inc;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= LOOP_NORMAL;
      hold_q <= '0;
    end else begin
      mode_q <= mode_d;
      hold_q <= hold_d;
    end
  end

  assign fast_o = (mode_q == LOOP_FAST);

endmodule

// File: rtl/blc_dac.sv
module blc_dac
  import blc_pkg::*;
#(
  parameter int CODE_W     = 10,
  parameter int DAC_W      = 10,
  parameter int NORM_SHIFT = 3,
  localparam int MAX_SH    = 5,
  localparam int STEP_W    = CODE_W + 1 + MAX_SH,
  localparam int ACC_W     = ((STEP_W > DAC_W) ? STEP_W : DAC_W) + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     meas_v_i,
  input  logic                     fast_i,
  input  logic signed [CODE_W:0]   err_i,
  input  logic [1:0]               mult_sel_i,
  output logic signed [STEP_W-1:0] step_o,
  output logic [DAC_W-1:0]         dac_o
);

  logic signed [STEP_W-1:0] err_x, step;
  logic signed [ACC_W-1:0]  sum, dac_max;
  logic [DAC_W-1:0]         dac_q, dac_d;

  assign err_x   = {{MAX_SH{err_i[CODE_W]}}, err_i};
  assign step    = fast_i ? (err_x <<< mult_shift(mult_sel_i)) : (err_x >>> NORM_SHIFT);
  assign sum     = $signed({{(ACC_W-DAC_W){1'b0}}, dac_q}) +
                   $signed({{(ACC_W-STEP_W){step[STEP_W-1]}}, step});
  assign dac_max = $signed({{(ACC_W-DAC_W){1'b0}}, {DAC_W{1'b1}}});

  always_comb begin
    dac_d = dac_q;
    if (meas_v_i) begin
      if (sum < 0) begin
        dac_d = '0;
      end else if (sum > dac_max) begin
        dac_d = {DAC_W{1'b1}};
      end else begin
        dac_d = sum[DAC_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_q <= {1'b1, {(DAC_W-1){1'b0}}};
    end else if (meas_v_i) begin
      dac_q <= dac_d;
    end
  end

  assign step_o = step;
  assign dac_o  = dac_q;

endmodule

// File: rtl/blc_loop.sv
module blc_loop
  import blc_pkg::*;
#(
  parameter int CODE_W     = 10,
  parameter int DAC_W      = 10,
  parameter int WIN_FIRST  = 5,
  parameter int WIN_LEN    = 8,
  parameter int LINES      = 4,
  parameter int NORM_SHIFT = 3,
  parameter int FAST_TH    = 32,
  localparam int SUM_W     = CODE_W + $clog2(WIN_LEN),
  localparam int STEP_W    = CODE_W + 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              ob_i,
  input  logic              ob_inv_i,
  input  logic [4:0]        clamp_sel_i,
  input  logic              avg4_i,
  input  logic              gain_chg_i,
  input  logic [1:0]        mult_sel_i,
  input  logic [1:0]        hold_sel_i,
  output logic [DAC_W-1:0]  dac_o,
  output logic              fast_o
);

  logic                     win_done, meas_v, err_big;
  logic [SUM_W-1:0]         win_sum;
  logic [CODE_W-1:0]        meas_code;
  logic signed [CODE_W:0]   err;
  logic [CODE_W:0]          err_mag;
  logic signed [STEP_W-1:0] step_s;

  blc_obwin #(.CODE_W(CODE_W), .WIN_FIRST(WIN_FIRST), .WIN_LEN(WIN_LEN)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_i(code_i), .ob_i(ob_i), .ob_inv_i(ob_inv_i),
    .win_done_o(win_done), .win_sum_o(win_sum)
  );

  blc_avg #(.CODE_W(CODE_W), .WIN_LEN(WIN_LEN), .LINES(LINES)) u_avg (
    .clk_i(clk_i), .rst_ni(rst_ni), .win_done_i(win_done), .win_sum_i(win_sum),
    .avg4_i(avg4_i), .meas_v_o(meas_v), .meas_code_o(meas_code)
  );

  assign err     = $signed({{(CODE_W-6){1'b0}}, target_code(clamp_sel_i)}) -
                   $signed({1'b0, meas_code});
  assign err_mag = err[CODE_W] ? (CODE_W+1)'(-err) : (CODE_W+1)'(err);
  assign err_big = err_mag > (CODE_W+1)'(FAST_TH);

  blc_lead u_lead (
    .clk_i(clk_i), .rst_ni(rst_ni), .gain_chg_i(gain_chg_i), .meas_v_i(meas_v),
    .err_big_i(err_big), .hold_sel_i(hold_sel_i), .fast_o(fast_o)
  );

  blc_dac #(.CODE_W(CODE_W), .DAC_W(DAC_W), .NORM_SHIFT(NORM_SHIFT)) u_dac (
    .clk_i(clk_i), .rst_ni(rst_ni), .meas_v_i(meas_v), .fast_i(fast_o), .err_i(err),
    .mult_sel_i(mult_sel_i), .step_o(step_s), .dac_o(dac_o)
  );

endmodule

// File: rtl/blc_loop_chk.sv
module blc_loop_chk #(
  parameter int DAC_W  = 10,
  parameter int STEP_W = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     gain_chg_i,
  input logic                     win_done,
  input logic                     meas_v,
  input logic signed [STEP_W-1:0] step_s,
  input logic [DAC_W-1:0]         dac_o,
  input logic                     fast_o
);

  p_dac_only_on_meas_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !meas_v |=> $stable(dac_o));

  p_no_wrap_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_v && step_s > 0) |=> dac_o >= $past(dac_o));

  p_no_wrap_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_v && step_s < 0) |=> dac_o <= $past(dac_o));

  p_meas_after_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_v |-> win_done);

  p_fast_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_chg_i |=> fast_o);

  p_fast_exit_on_meas_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fast_o) |-> $past(meas_v));

endmodule

bind blc_loop blc_loop_chk #(.DAC_W(DAC_W), .STEP_W(STEP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .gain_chg_i(gain_chg_i), .win_done(win_done),
  .meas_v(meas_v), .step_s(step_s), .dac_o(dac_o), .fast_o(fast_o)
);

// File: tb/test_blc_loop.sv
module test_blc_loop;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [9:0] code_i;
  logic       ob_i, ob_inv_i, avg4_i, gain_chg_i;
  logic [4:0] clamp_sel_i;
  logic [1:0] mult_sel_i, hold_sel_i;
  logic [9:0] dac_o;
  logic       fast_o;

  int n_chk = 0;
  int n_fail = 0;
  int dac_e, fast_e, hold_e, lsum, lcnt;

  always #4 clk_i = ~clk_i;

  blc_loop i_blc_loop (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_i(code_i), .ob_i(ob_i), .ob_inv_i(ob_inv_i),
    .clamp_sel_i(clamp_sel_i), .avg4_i(avg4_i), .gain_chg_i(gain_chg_i),
    .mult_sel_i(mult_sel_i), .hold_sel_i(hold_sel_i), .dac_o(dac_o), .fast_o(fast_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check({req, " dac"}, int'(dac_o), dac_e);
    check({req, " fast"}, int'(fast_o), fast_e);
  endtask

  // expected loop update for one measurement
  task automatic apply_meas(input int avg);
    int err, step, mag;
    err = (int'(clamp_sel_i) * 2 + 14) - avg;
    mag = (err < 0) ? -err : err;
    step = fast_e ? err * (4 << mult_sel_i) : (err >>> 3);
    dac_e = dac_e + step;
    if (dac_e < 0) dac_e = 0;
    if (dac_e > 1023) dac_e = 1023;
    if (fast_e != 0) begin
      if (mag > 32) hold_e = 0;
      else begin
        hold_e++;
        if (hold_e >= (1 << hold_sel_i)) begin
          fast_e = 0;
          hold_e = 0;
        end
      end
    end
  endtask

  task automatic model_window(input int s);
    lsum += s;
    lcnt++;
    if (!avg4_i) begin
      lsum = 0; lcnt = 0;
      apply_meas(s >> 3);
    end else if (lcnt == 4) begin
      apply_meas(lsum >> 5);
      lsum = 0; lcnt = 0;
    end
  endtask

  // edge 0 is the next rising edge; codes outside edges 5..12 are full scale
  task automatic drive_window(input int base, input int stride, output int s);
    s = 0;
    @(negedge clk_i); ob_i = ~ob_inv_i; code_i = 10'd1023;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk_i);
      ob_i = (k < 3) ? ~ob_inv_i : ob_inv_i;
      if (k >= 5) begin
        code_i = 10'(base + stride * k);
        s += base + stride * k;
      end else code_i = 10'd1023;
    end
    @(negedge clk_i); ob_i = ob_inv_i; code_i = 10'd1023;
  endtask

  task automatic line(input int base, input int stride, input string req);
    int s;
    drive_window(base, stride, s);
    model_window(s);
    @(negedge clk_i);
    check_state(req);
  endtask

  task automatic gain_pulse();
    @(negedge clk_i); gain_chg_i = 1'b1;
    @(negedge clk_i); gain_chg_i = 1'b0;
    fast_e = 1; hold_e = 0;
    check_state("R7 entry");
  endtask

  task automatic t_reset();
    check_state("R1 reset");
  endtask

  task automatic t_window();
    clamp_sel_i = 5'd9;
    line(20, 2, "R2 R4 ramp floor");
    line(0, 1, "R2 R4 positive");
    line(40, 0, "R4 neg -8");
  endtask

  task automatic t_target();
    clamp_sel_i = 5'd0;  line(0, 0, "R3 min target");
    clamp_sel_i = 5'd31; line(0, 0, "R3 max target");
    clamp_sel_i = 5'd9;
  endtask

  task automatic t_polarity();
    ob_i = 1'b1; ob_inv_i = 1'b1;
    @(negedge clk_i);
    clamp_sel_i = 5'd31;
    line(40, 0, "R11 inverted pulse");
    line(90, 1, "R11 inverted ramp");
    ob_inv_i = 1'b0; ob_i = 1'b0;
    @(negedge clk_i);
    clamp_sel_i = 5'd9;
  endtask

  task automatic t_avg4();
    avg4_i = 1'b1;
    clamp_sel_i = 5'd31;
    line(100, 0, "R6 line1 hold");
    line(0, 3, "R6 line2 hold");
    line(200, 1, "R6 line3 hold");
    line(50, 0, "R6 pooled update");
    avg4_i = 1'b0;
    clamp_sel_i = 5'd9;
  endtask

  task automatic t_mult();
    hold_sel_i = 2'd0;
    for (int m = 0; m < 4; m++) begin
      mult_sel_i = 2'(m);
      gain_pulse();
      line(24, 0, "R7 multiplier R9 exit after 1");
    end
  endtask

  task automatic t_hold();
    mult_sel_i = 2'd0; hold_sel_i = 2'd1;
    gain_pulse();
    line(100, 0, "R8 big error stays fast");
    line(0, 0, "R9 error 32 counts");
    line(65, 0, "R8 error -33 restarts");
    line(30, 0, "R9 first small");
    line(30, 0, "R9 second small exits");
    line(45, 0, "R4 normal after exit");
    hold_sel_i = 2'd3;
    gain_pulse();
    for (int i = 0; i < 8; i++) line(31, 0, "R9 hold eight");
    hold_sel_i = 2'd2;
    gain_pulse();
    for (int i = 0; i < 4; i++) line(33, 0, "R9 hold four");
  endtask

  task automatic t_sat();
    mult_sel_i = 2'd3; hold_sel_i = 2'd3;
    clamp_sel_i = 5'd31;
    gain_pulse();
    line(0, 0, "R5 high rail");
    line(0, 0, "R5 high rail held");
    clamp_sel_i = 5'd0;
    line(1000, 1, "R5 low rail");
    clamp_sel_i = 5'd9; hold_sel_i = 2'd0;
    line(30, 0, "R5 leave rail");
  endtask

  task automatic t_retrig();
    int s;
    clamp_sel_i = 5'd9;
    // partial window full of full-scale codes, interrupted by a new pulse
    @(negedge clk_i); ob_i = 1'b1; code_i = 10'd1023;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk_i); ob_i = (k < 3); code_i = 10'd1023;
    end
    check_state("R10 no update mid window");
    drive_window(10, 2, s);
    model_window(s);
    @(negedge clk_i);
    check_state("R10 restart");
  endtask

  initial begin
    rst_ni = 1'b0; code_i = '0; ob_i = 1'b0; ob_inv_i = 1'b0; avg4_i = 1'b0;
    gain_chg_i = 1'b0; clamp_sel_i = 5'd9; mult_sel_i = '0; hold_sel_i = '0;
    dac_e = 512; fast_e = 0; hold_e = 0; lsum = 0; lcnt = 0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_window();
    t_target();
    t_polarity();
    t_avg4();
    t_mult();
    t_hold();
    t_sat();
    t_retrig();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule